// File: doc/BRIEF.md
# Debug Watchpoint Comparator Unit

This unit sits next to a soft CPU core and gives a host debugger a set of hardware breakpoints and watchpoints. Each comparator pair has a 32-bit value register and an 8-bit control field. Both are reached through a simple 32-bit register port. In every cycle each configured pair compares one quantity from the CPU bus against its value register. The quantity can be the instruction fetch address, a load or store address, or load or store data. The pair uses the relation and the signedness set in its control field.

When any pair matches, the unit raises a debug exception toward the core. It also emits a single-cycle event record that carries the index of the matching pair and the bus value that was compared, so the host learns why the core stopped. Each pair sends one event per match episode. A held match sends no further events until the match drops or the host acknowledges through the status register.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset every value, control and status register reads zero, and `dbg_exc_o` and `evt_valid_o` are low.
- R2: Register address 2k selects the 32-bit value register of pair k, address 2k+1 selects its control register, and address 2·NUM_PAIRS selects the status register. All other addresses read zero. A write takes effect in the compares of the following cycle.
- R3: In a control register, bits 31:8 always read zero and ignore writes.
- R4: Control bit 0 marks the pair as present. While it is clear, the pair never matches, whatever the other fields hold.
- R5: Control bits 7:5 select the compare operand: 000 off, 001 fetch address, 010 load address, 011 store address, 100 load data, 101 store data, 110 load-or-store address, 111 load-or-store data. Each operand counts only while its valid strobe is high. For codes 110 and 111 the load side is used when both strobes are high.
- R6: Control bits 3:1 select the relation "operand OP value": 000 never, 001 equal, 010 less, 011 less-or-equal, 100 greater, 101 greater-or-equal, 110 not-equal, 111 never.
- R7: Control bit 4 set makes the relations signed two's-complement compares. Clear makes them unsigned.
- R8: `dbg_exc_o` is high in the cycle after any pair matches, and low in the cycle after no pair matches.
- R9: In the cycle after a pair becomes eligible to report, `evt_valid_o` pulses for one cycle. `evt_idx_o` and `evt_value_o` then hold the lowest eligible pair index and its compared operand. Eligible pairs with higher indices report in later cycles.
- R10: A pair that has reported stays quiet while its match holds. The status register reads one pending bit per pair (bit k for pair k). Writing 1 to bit k re-arms pair k. A cycle without a match also re-arms it. If a report and an acknowledge hit the same cycle, the report wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Write enable for the access |
| reg_addr_i | input | AW (4) | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current address, combinational |
| fetch_valid_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | 32 | Fetch address |
| load_valid_i | input | 1 | Load strobe |
| load_addr_i | input | 32 | Load effective address |
| load_data_i | input | 32 | Load data |
| store_valid_i | input | 1 | Store strobe |
| store_addr_i | input | 32 | Store effective address |
| store_data_i | input | 32 | Store data |
| dbg_exc_o | output | 1 | Debug exception request to the core |
| evt_valid_o | output | 1 | Event record valid, one cycle |
| evt_idx_o | output | IW (2) | Index of the reporting pair |
| evt_value_o | output | 32 | Operand that matched |

## Verification
The bench drives a stimulus sequence that targets these corner cases:

- **Signedness.** Operands such as 0x80000000 and 0xFFFFFFF0 are set against small positive values under every relation. A design that ignores the sign bit reverses the less and greater results on these operands.
- **Held matches.** A design that re-fires on a level, instead of once per episode, floods the event port while the fetch address stays put.
- **Priority and re-arming.** Several pairs match at once. A design that drops the lower-priority pairs, or marks them as reported, loses their events. A design that ignores an acknowledge under a steady match never re-arms.
- **Field decoding.** Reserved control bits, clear present bits and strobe gating are tested against stale bus values. A mis-decoded field or a missing strobe qualifier gives spurious matches.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int CTL_W    = 8;
  localparam int PRES_BIT = 0;
  localparam int COND_LSB = 1;
  localparam int SIGN_BIT = 4;
  localparam int TGT_LSB  = 5;

  typedef enum logic [2:0] {
    TGT_OFF, TGT_FETCH, TGT_LD_ADDR, TGT_ST_ADDR,
    TGT_LD_DATA, TGT_ST_DATA, TGT_LS_ADDR, TGT_LS_DATA
  } tgt_e;

  typedef enum logic [2:0] {
    CND_NEVER, CND_EQ, CND_LT, CND_LE, CND_GT, CND_GE, CND_NE, CND_RSVD
  } cond_e;
endpackage

// File: rtl/dbg_watch_pair.sv
module dbg_watch_pair
  import dbg_watch_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_val_i,
  input  logic             wr_ctl_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             fetch_valid_i,
  input  logic [DW-1:0]    fetch_addr_i,
  input  logic             load_valid_i,
  input  logic [DW-1:0]    load_addr_i,
  input  logic [DW-1:0]    load_data_i,
  input  logic             store_valid_i,
  input  logic [DW-1:0]    store_addr_i,
  input  logic [DW-1:0]    store_data_i,
  output logic [DW-1:0]    val_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             match_o,
  output logic [DW-1:0]    operand_o
);
  logic [DW-1:0]    val_q;
  logic [CTL_W-1:0] ctl_q;
  tgt_e             tgt;
  cond_e            cond;
  logic             op_vld, is_eq, is_lt, hit;
  logic [DW-1:0]    op;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_val_i) val_q <= wdata_i;
      if (wr_ctl_i) ctl_q <= wdata_i[CTL_W-1:0];  // upper bits dropped
    end
  end

  always_comb begin
    tgt  = tgt_e'(ctl_q[TGT_LSB+:3]);
    cond = cond_e'(ctl_q[COND_LSB+:3]);
    op_vld = 1'b0;
    op     = '0;
    unique case (tgt)
      TGT_FETCH:   begin op_vld = fetch_valid_i; op = fetch_addr_i; end
      TGT_LD_ADDR: begin op_vld = load_valid_i;  op = load_addr_i;  end
      TGT_ST_ADDR: begin op_vld = store_valid_i; op = store_addr_i; end
      TGT_LD_DATA: begin op_vld = load_valid_i;  op = load_data_i;  end
      TGT_ST_DATA: begin op_vld = store_valid_i; op = store_data_i; end
      TGT_LS_ADDR: begin
        op_vld = load_valid_i | store_valid_i;
        op     = load_valid_i ? load_addr_i : store_addr_i;
      end
      TGT_LS_DATA: begin
        op_vld = load_valid_i | store_valid_i;
        op     = load_valid_i ? load_data_i : store_data_i;
      end
      default: ;
    endcase
    is_eq = (op == val_q);
    is_lt = ctl_q[SIGN_BIT] ? ($signed(op) < $signed(val_q)) : (op < val_q);
    unique case (cond)
      CND_EQ:  hit = is_eq;
      CND_LT:  hit = is_lt;
      CND_LE:  hit = is_lt | is_eq;
      CND_GT:  hit = ~is_lt & ~is_eq;
      CND_GE:  hit = ~is_lt;
      CND_NE:  hit = ~is_eq;
      default: hit = 1'b0;
    endcase
  end

  assign match_o   = ctl_q[PRES_BIT] & op_vld & hit;
  assign operand_o = op;
  assign val_o     = val_q;
  assign ctl_o     = ctl_q;

  assert_match_cfg_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (ctl_q[PRES_BIT] && tgt != TGT_OFF && cond != CND_NEVER && cond != CND_RSVD));
endmodule

// File: rtl/dbg_watch_evt.sv
module dbg_watch_evt #(
  parameter int N  = 4,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         match_i,
  input  logic [N-1:0][DW-1:0] operand_i,
  input  logic [N-1:0]         ack_i,
  output logic [N-1:0]         sent_o,
  output logic                 exc_o,
  output logic                 evt_valid_o,
  output logic [IW-1:0]        evt_idx_o,
  output logic [DW-1:0]        evt_value_o
);
  logic [N-1:0]  sent_q, elig, grant;
  logic [IW-1:0] pick;
  logic          any;

  assign elig = match_i & ~sent_q;
  assign any  = |elig;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (elig[i]) pick = IW'(i);
    grant = any ? (N'(1) << pick) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_q      <= '0;
      exc_o       <= 1'b0;
      evt_valid_o <= 1'b0;
      evt_idx_o   <= '0;
      evt_value_o <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (grant[i])                  sent_q[i] <= 1'b1;
        else if (ack_i[i] || !match_i[i]) sent_q[i] <= 1'b0;
      end
      exc_o       <= |match_i;
      evt_valid_o <= any;
      if (any) begin
        evt_idx_o   <= pick;
        evt_value_o <= operand_i[pick];
      end
    end
  end

  assign sent_o = sent_q;

  assert_grant_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_evt_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (($past(elig) & ((N'(1) << evt_idx_o) - N'(1))) == '0));
  assert_evt_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> ((($past(elig)) >> evt_idx_o) & N'(1)) != '0);

  for (genvar g = 0; g < N; g++) begin : g_norefire
    assert_no_refire_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sent_q[g] |=> !(evt_valid_o && evt_idx_o == IW'(g)));
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int DW        = 32,
  localparam int AW = $clog2(2 * NUM_PAIRS + 1),
  localparam int IW = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          fetch_valid_i,
  input  logic [DW-1:0] fetch_addr_i,
  input  logic          load_valid_i,
  input  logic [DW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          store_valid_i,
  input  logic [DW-1:0] store_addr_i,
  input  logic [DW-1:0] store_data_i,
  output logic          dbg_exc_o,
  output logic          evt_valid_o,
  output logic [IW-1:0] evt_idx_o,
  output logic [DW-1:0] evt_value_o
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(2 * NUM_PAIRS);

  logic                         wr;
  logic [NUM_PAIRS-1:0]         match, sent, ack;
  logic [NUM_PAIRS-1:0][DW-1:0] val_arr, ops;
  logic [NUM_PAIRS-1:0][CTL_W-1:0] ctl_arr;
  logic [IW-1:0]                sel;

  assign wr  = reg_req_i & reg_we_i;
  assign ack = (wr && reg_addr_i == STAT_ADDR) ? reg_wdata_i[NUM_PAIRS-1:0] : '0;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    dbg_watch_pair #(.DW(DW)) u_pair (
      .clk_i, .rst_ni,
      .wr_val_i      (wr && reg_addr_i == AW'(2 * g)),
      .wr_ctl_i      (wr && reg_addr_i == AW'(2 * g + 1)),
      .wdata_i       (reg_wdata_i),
      .fetch_valid_i, .fetch_addr_i,
      .load_valid_i,  .load_addr_i,  .load_data_i,
      .store_valid_i, .store_addr_i, .store_data_i,
      .val_o         (val_arr[g]),
      .ctl_o         (ctl_arr[g]),
      .match_o       (match[g]),
      .operand_o     (ops[g])
    );
  end

  dbg_watch_evt #(.N(NUM_PAIRS), .DW(DW)) u_evt (
    .clk_i, .rst_ni,
    .match_i     (match),
    .operand_i   (ops),
    .ack_i       (ack),
    .sent_o      (sent),
    .exc_o       (dbg_exc_o),
    .evt_valid_o,
    .evt_idx_o,
    .evt_value_o
  );

  assign sel = reg_addr_i[IW:1];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < STAT_ADDR)
      reg_rdata_o = reg_addr_i[0] ? DW'(ctl_arr[sel]) : val_arr[sel];
    else if (reg_addr_i == STAT_ADDR)
      reg_rdata_o = DW'(sent);
  end

  assert_ctl_rsvd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i < STAT_ADDR && reg_addr_i[0]) |-> reg_rdata_o[DW-1:CTL_W] == '0);
  assert_evt_has_exc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> dbg_exc_o);
endmodule

// File: tb/dbg_watch_unit_tb.sv
module dbg_watch_unit_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 0, reg_we_i = 0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        fetch_valid_i = 0, load_valid_i = 0, store_valid_i = 0;
  logic [31:0] fetch_addr_i = '0, load_addr_i = '0, load_data_i = '0;
  logic [31:0] store_addr_i = '0, store_data_i = '0;
  logic        dbg_exc_o, evt_valid_o;
  logic [1:0]  evt_idx_o;
  logic [31:0] evt_value_o;

  always #10 clk = ~clk;

  dbg_watch_unit u_dut (.clk_i(clk), .*);

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 0;

  logic [31:0] m_val[N];
  logic [7:0]  m_ctl[N];
  bit          m_sent[N];
  bit          e_exc, e_ev;
  int          e_idx;
  logic [31:0] e_value;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_match(int k, output logic [31:0] op);
    bit v = 0;
    longint a, b;
    bit lt, eq, hit;
    op = '0;
    case (m_ctl[k][7:5])
      3'd1: begin v = fetch_valid_i; op = fetch_addr_i; end
      3'd2: begin v = load_valid_i;  op = load_addr_i;  end
      3'd3: begin v = store_valid_i; op = store_addr_i; end
      3'd4: begin v = load_valid_i;  op = load_data_i;  end
      3'd5: begin v = store_valid_i; op = store_data_i; end
      3'd6: begin v = load_valid_i || store_valid_i; op = load_valid_i ? load_addr_i : store_addr_i; end
      3'd7: begin v = load_valid_i || store_valid_i; op = load_valid_i ? load_data_i : store_data_i; end
      default: v = 0;
    endcase
    if (m_ctl[k][4]) begin a = longint'($signed(op)); b = longint'($signed(m_val[k])); end
    else begin a = longint'({32'd0, op}); b = longint'({32'd0, m_val[k]}); end
    lt = a < b; eq = a == b;
    case (m_ctl[k][3:1])
      3'd1: hit = eq;
      3'd2: hit = lt;
      3'd3: hit = lt || eq;
      3'd4: hit = !lt && !eq;
      3'd5: hit = !lt;
      3'd6: hit = !eq;
      default: hit = 0;
    endcase
    return m_ctl[k][0] && v && hit;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    logic [31:0] r = '0;
    if (a < 4'(2 * N)) r = a[0] ? {24'd0, m_ctl[a[3:1]]} : m_val[a[3:1]];
    else if (a == 4'(2 * N))
      for (int k = 0; k < N; k++) r[k] = m_sent[k];
    return r;
  endfunction

  task automatic model_step();
    bit mt[N];
    logic [31:0] ops[N];
    logic [N-1:0] ackv = '0;
    int pick = -1;
    for (int k = 0; k < N; k++) mt[k] = m_match(k, ops[k]);
    e_exc = 0;
    for (int k = 0; k < N; k++) begin
      if (mt[k]) e_exc = 1;
      if (pick < 0 && mt[k] && !m_sent[k]) pick = k;
    end
    e_ev = pick >= 0;
    if (e_ev) begin e_idx = pick; e_value = ops[pick]; end
    if (reg_req_i && reg_we_i && reg_addr_i == 4'(2 * N)) ackv = reg_wdata_i[N-1:0];
    for (int k = 0; k < N; k++)
      if (k == pick) m_sent[k] = 1;
      else if (ackv[k] || !mt[k]) m_sent[k] = 0;
    if (reg_req_i && reg_we_i && reg_addr_i < 4'(2 * N)) begin
      if (reg_addr_i[0]) m_ctl[reg_addr_i[3:1]] = reg_wdata_i[7:0];
      else               m_val[reg_addr_i[3:1]] = reg_wdata_i;
    end
  endtask

  task automatic compare();
    chk("dbg_exc (R8)", 32'(dbg_exc_o), 32'(e_exc));
    chk("evt_valid (R9/R10)", 32'(evt_valid_o), 32'(e_ev));
    if (e_ev && evt_valid_o) begin
      chk("evt_idx (R9)", 32'(evt_idx_o), 32'(e_idx));
      chk("evt_value (R9)", evt_value_o, e_value);
    end
    if (reg_req_i && !reg_we_i) chk("rdata (R2)", reg_rdata_o, m_read(reg_addr_i));
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); model_step();
      @(negedge clk); compare();
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic rd(logic [3:0] a);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = a;
    cyc();
    reg_req_i = 0;
  endtask

  task automatic bus_idle();
    fetch_valid_i = 0; load_valid_i = 0; store_valid_i = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    logic [31:0] pats[6];
    for (int k = 0; k < N; k++) begin m_val[k] = '0; m_ctl[k] = '0; m_sent[k] = 0; end
    e_exc = 0; e_ev = 0; e_idx = 0; e_value = '0;

    // R1: reset state, all addresses read zero
    repeat (2) @(negedge clk);
    chk("reset exc R1", 32'(dbg_exc_o), 0);
    chk("reset evt R1", 32'(evt_valid_o), 0);
    for (int a = 0; a <= 2 * N; a++) begin
      reg_addr_i = 4'(a); #1;
      chk("reset rdata R1", reg_rdata_o, 0);
    end
    @(negedge clk); rst_ni = 1;

    tag = "R2";
    wr(0, 32'hDEADBEEF); rd(0);
    wr(0, 32'h0000_1000); rd(0); rd(4'(2 * N + 1));
    tag = "R3";
    wr(1, 32'hFFFF_FF23); rd(1);      // present, equal, fetch

    tag = "R10";
    fetch_valid_i = 1; fetch_addr_i = 32'h0FFC; cyc();
    fetch_addr_i = 32'h1000; cyc(3);
    rd(4'(2 * N));
    fetch_addr_i = 32'h1004; cyc();
    fetch_addr_i = 32'h1000; cyc(2);
    wr(4'(2 * N), 32'h1); cyc(2);     // ack under a held match
    tag = "R5";
    fetch_valid_i = 0; cyc(2);
    tag = "R4";
    wr(1, 32'h22); fetch_valid_i = 1; cyc(3);
    wr(1, 0); bus_idle(); cyc();

    tag = "R5";
    wr(2, 32'h55);
    for (int t = 2; t < 8; t++) begin
      wr(3, 32'(t << 5) | 32'h3);
      for (int p = 0; p < 7; p++) begin
        bus_idle();
        load_addr_i = 0; load_data_i = 0; store_addr_i = 0; store_data_i = 0;
        case (p)
          0: begin load_valid_i = 1; load_addr_i = 32'h55; end
          1: begin store_valid_i = 1; store_addr_i = 32'h55; end
          2: begin load_valid_i = 1; load_data_i = 32'h55; end
          3: begin store_valid_i = 1; store_data_i = 32'h55; end
          4: begin load_valid_i = 1; store_valid_i = 1; load_addr_i = 32'h11; store_addr_i = 32'h55; load_data_i = 32'h55; end
          5: begin load_valid_i = 1; store_valid_i = 1; store_addr_i = 32'h55; store_data_i = 32'h55; end
          default: begin load_addr_i = 32'h55; store_data_i = 32'h55; end
        endcase
        cyc(); bus_idle(); cyc();
      end
    end
    wr(3, 0);

    tag = "R6";
    pats[0] = 32'h0F; pats[1] = 32'h10; pats[2] = 32'h11;
    pats[3] = 32'hFFFF_FFF0; pats[4] = 32'h7FFF_FFFF; pats[5] = 32'h8000_0000;
    for (int s = 0; s < 2; s++) begin
      if (s) tag = "R7";
      for (int vv = 0; vv < 2; vv++) begin
        wr(4, vv ? 32'hFFFF_FFF0 : 32'h10);
        for (int c = 0; c < 8; c++) begin
          wr(5, 32'h21 | 32'(s << 4) | 32'(c << 1));
          for (int p = 0; p < 6; p++) begin
            fetch_valid_i = 1; fetch_addr_i = pats[p]; cyc();
            bus_idle(); cyc();
          end
        end
      end
    end

    tag = "R9";
    for (int k = 0; k < N; k++) begin wr(4'(2 * k), 32'h2000); wr(4'(2 * k + 1), 32'h23); end
    fetch_valid_i = 1; fetch_addr_i = 32'h2000; cyc(6);
    rd(4'(2 * N));
    wr(4'(2 * N), 32'hF); cyc(6);
    wr(4'(2 * N), 32'h4); cyc(2);
    bus_idle(); cyc(2);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      summary();
      $finish;
    end
  end
endmodule